// File: doc/BRIEF.md
# Iterative Table-Driven Block Encryptor (128-bit key)

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher, one round per clock cycle. A one-cycle start pulse loads the plaintext and the key. The block first adds the key to the plaintext. It then runs nine regular rounds and one final round. Each regular round is a network of 32-bit table lookups and XORs. Byte substitution, the row rotation and the column mixing are folded into four tables, one for each state row. The row rotation is folded into the way the tables are addressed.

The round keys are not stored. Each one is derived from the previous round key in the same cycle that uses it. When the tenth round completes, the ciphertext is captured in an output register and a done flag pulses for one cycle. The caller can leave start asserted or pulse it at any time: it has no effect until the current block has finished.

Top module: `aes_tt_encrypt`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `done` is 0 and `ct` is all zeros.
- R2: Before the first round, the state equals the plaintext XOR the cipher key.
- R3: In rounds 1 to 9, output column c is the XOR of round-key word c with T0[s(0,c)], T1[s(1,c+1)], T2[s(2,c+2)] and T3[s(3,c+3)]. The column indices are taken mod 4. For S = sbox(b), T0[b] is the word {2·S, S, S, 3·S}, with the first element in the most significant byte. T_r is T0 rotated right by 8·r bits. Multiplication is in GF(2^8) with the polynomial 0x11b.
- R4: Round 10 applies only the S-box and the row rotation before the key addition. Output byte (r,c) is sbox(s(r,(c+r) mod 4)) XOR key byte (r,c), with no column mixing.
- R5: Round key i is derived from round key i-1 in the cycle that uses it. Take the last word, rotate it left by one byte and pass each byte through the S-box. XOR the round constant into its top byte. The round constants run 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. Then XOR this word into word 0, and XOR each word into the next one in turn.
- R6: If start is sampled high at a clock edge while the block is idle, `done` is high after the 11th edge counted from that one, and `ct` holds the ciphertext from that edge on.
- R7: `done` is high for exactly one cycle per block.
- R8: A start sampled while a block is in progress is ignored. The running block completes on schedule with its own result, and no second completion follows from the ignored start.
- R9: `ct` changes only at the edge that raises `done`, and it holds its value between completions.
- R10: Byte i of a 128-bit block sits at bits [127-8i : 120-8i]. Column c holds bytes 4c to 4c+3, and row r of column c is byte 4c+r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a block when the block is idle |
| pt | input | 128 | Plaintext, sampled with start |
| key | input | 128 | Cipher key, sampled with start |
| ct | output | 128 | Ciphertext of the last completed block |
| done | output | 1 | One-cycle pulse when ct is updated |

## Verification
The cipher geometry is fixed: four columns, ten rounds, 8-bit symbols. The bench therefore builds the block with its default parameters, which is its only meaningful configuration. It runs an exhaustive sweep of all 256 byte values in each of the four rows of one column. This reaches every entry of every row table in the first round, through the folded row-rotation addressing. Published test vectors and pseudo-random blocks are compared against an arithmetic model in the bench. Together they cover the whitening, the round-constant chain and the final round without column mixing. Timed start pulses check the latency, the single-cycle done pulse and the rule that a start during a running block is ignored.

// File: rtl/aes_tt_pkg.sv
`timescale 1ns/1ps
package aes_tt_pkg;

    localparam int NB     = 4;
    localparam int ROWS   = 4;
    localparam int NR     = 10;
    localparam int BYTE_W = 8;
    localparam int WORD_W = ROWS * BYTE_W;
    localparam int BLK_W  = NB * WORD_W;
    localparam int RND_W  = $clog2(NR + 2);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  block_t;
    typedef logic [RND_W-1:0]  rnd_t;

    localparam rnd_t  LAST_RND  = rnd_t'(NR);
    localparam byte_t RCON_INIT = 8'h01;
    localparam byte_t RED_POLY  = 8'h1b;
    localparam byte_t AFF_CONST = 8'h63;

    typedef enum logic {ST_IDLE, ST_RUN} ctl_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic last;
    } ctl_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? RED_POLY : byte_t'(0));
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // a^254 by repeated squaring; maps zero to zero
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t p;
        r = 8'h01;
        p = a;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t b, input int k);
        logic [2*BYTE_W-1:0] d;
        d = {b, b};
        return d[BYTE_W-k +: BYTE_W];
    endfunction

    function automatic byte_t sbox(input byte_t a);
        byte_t b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFF_CONST;
    endfunction

    // Row table entry: base word rotated right by one byte per row
    function automatic word_t t_word(input int r, input byte_t b);
        byte_t s;
        byte_t s2;
        word_t m;
        logic [2*WORD_W-1:0] d;
        s  = sbox(b);
        s2 = xtime(s);
        m  = {s2, s, s, s2 ^ s};
        d  = {m, m};
        return d[BYTE_W*r +: WORD_W];
    endfunction

    function automatic byte_t get_byte(input block_t blk, input int c, input int r);
        return blk[BLK_W - BYTE_W - WORD_W*c - BYTE_W*r +: BYTE_W];
    endfunction

    function automatic word_t get_word(input block_t blk, input int c);
        return blk[BLK_W - WORD_W*(c+1) +: WORD_W];
    endfunction

    function automatic word_t sub_word(input word_t w);
        word_t o;
        for (int r = 0; r < ROWS; r++)
            o[BYTE_W*r +: BYTE_W] = sbox(w[BYTE_W*r +: BYTE_W]);
        return o;
    endfunction

endpackage

// File: rtl/aes_tt_ctrl.sv
`timescale 1ns/1ps
module aes_tt_ctrl
    import aes_tt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output ctl_t ctl_o,
    output logic busy_o,
    output logic done_o,
    output rnd_t rnd_o
);

    ctl_state_e st_q;
    rnd_t       rnd_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        st_q  <= ST_RUN;
                        rnd_q <= rnd_t'(1);
                    end
                end
                ST_RUN: begin
                    if (rnd_q == LAST_RND) begin
                        st_q   <= ST_IDLE;
                        rnd_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        rnd_q <= rnd_q + rnd_t'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.load = (st_q == ST_IDLE) && start_i;
        ctl_o.step = (st_q == ST_RUN);
        ctl_o.last = (st_q == ST_RUN) && (rnd_q == LAST_RND);
    end

    assign busy_o = (st_q == ST_RUN);
    assign done_o = done_q;
    assign rnd_o  = rnd_q;

endmodule

// File: rtl/aes_tt_keysched.sv
`timescale 1ns/1ps
module aes_tt_keysched
    import aes_tt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  logic   step_i,
    input  block_t key_i,
    output block_t rk_next_o
);

    block_t key_q;
    byte_t  rcon_q;
    word_t  mix_w;
    word_t  last_w;

    assign last_w = get_word(key_q, NB-1);
    assign mix_w  = sub_word({last_w[WORD_W-BYTE_W-1:0], last_w[WORD_W-1 -: BYTE_W]})
                    ^ {rcon_q, {(WORD_W-BYTE_W){1'b0}}};

    always_comb begin
        word_t carry;
        carry     = mix_w;
        rk_next_o = '0;
        for (int i = 0; i < NB; i++) begin
            carry = carry ^ get_word(key_q, i);
            rk_next_o[BLK_W - WORD_W*(i+1) +: WORD_W] = carry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            rcon_q <= '0;
        end else if (load_i) begin
            key_q  <= key_i;
            rcon_q <= RCON_INIT;
        end else if (step_i) begin
            key_q  <= rk_next_o;
            rcon_q <= xtime(rcon_q);
        end
    end

endmodule

// File: rtl/aes_tt_round.sv
`timescale 1ns/1ps
module aes_tt_round
    import aes_tt_pkg::*;
(
    input  block_t st_i,
    input  block_t rk_i,
    input  logic   last_i,
    output block_t st_o
);

    for (genvar c = 0; c < NB; c++) begin : g_col
        word_t col_w;
        always_comb begin
            byte_t b;
            col_w = get_word(rk_i, c);
            for (int r = 0; r < ROWS; r++) begin
                b = get_byte(st_i, (c + r) % NB, r);
                if (last_i)
                    col_w = col_w ^ (word_t'(sbox(b)) << (BYTE_W*(ROWS-1-r)));
                else
                    col_w = col_w ^ t_word(r, b);
            end
        end
        assign st_o[BLK_W - WORD_W*(c+1) +: WORD_W] = col_w;
    end

endmodule

// File: rtl/aes_tt_encrypt.sv
`timescale 1ns/1ps
module aes_tt_encrypt
    import aes_tt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [127:0] pt,
    input  logic [127:0] key,
    output logic [127:0] ct,
    output logic         done
);

    ctl_t   ctl;
    logic   busy;
    rnd_t   rnd;
    block_t state_q;
    block_t ct_q;
    block_t rk_next;
    block_t round_out;

    aes_tt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .ctl_o   (ctl),
        .busy_o  (busy),
        .done_o  (done),
        .rnd_o   (rnd)
    );

    aes_tt_keysched u_key (
        .clk       (clk),
        .rst       (rst),
        .load_i    (ctl.load),
        .step_i    (ctl.step),
        .key_i     (key),
        .rk_next_o (rk_next)
    );

    aes_tt_round u_round (
        .st_i   (state_q),
        .rk_i   (rk_next),
        .last_i (ctl.last),
        .st_o   (round_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            ct_q    <= '0;
        end else begin
            if (ctl.load)
                state_q <= pt ^ key;
            else if (ctl.step)
                state_q <= round_out;
            if (ctl.last)
                ct_q <= round_out;
        end
    end

    assign ct = ct_q;

endmodule

// File: rtl/aes_tt_checker.sv
`timescale 1ns/1ps
module aes_tt_checker
    import aes_tt_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         done,
    input logic [127:0] ct,
    input logic         busy,
    input rnd_t         rnd
);

    rnd_t since_q;

    always_ff @(posedge clk) begin
        if (rst)
            since_q <= '0;
        else if (start && !busy)
            since_q <= rnd_t'(1);
        else if (since_q == rnd_t'(NR + 1))
            since_q <= '0;
        else if (since_q != '0)
            since_q <= since_q + rnd_t'(1);
    end

    assert_done_timing_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> since_q == rnd_t'(NR + 1));

    assert_done_due_R6: assert property (@(posedge clk) disable iff (rst)
        since_q == rnd_t'(NR + 1) |-> done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && rnd != LAST_RND) |=> (busy && rnd == $past(rnd) + rnd_t'(1)));

    assert_ct_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ct));

endmodule

bind aes_tt_encrypt aes_tt_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .done  (done),
    .ct    (ct),
    .busy  (busy),
    .rnd   (rnd)
);

// File: tb/sim_aes_tt_encrypt.sv
`timescale 1ns/1ps
module sim_aes_tt_encrypt;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] pt = '0;
    logic [127:0] key = '0;
    logic [127:0] ct;
    logic         done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] sb [256];

    always #2.5 clk = ~clk;

    aes_tt_encrypt u0 (
        .clk(clk), .rst(rst), .start(start), .pt(pt), .key(key), .ct(ct), .done(done)
    );

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] o;
            for (int y = 1; y < 256; y++)
                if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
            sb[x] = o ^ 8'h63;
        end
    endtask

    // Step-by-step reference: separate substitution, row shift, mixing, key add
    function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
        logic [31:0] w [44];
        logic [7:0]  s [16];
        logic [7:0]  t [16];
        logic [7:0]  rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
            if (rd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0 = s[4*c], a1 = s[4*c+1], a2 = s[4*c+2], a3 = s[4*c+3];
                    s[4*c]   = bmul(a0, 2) ^ bmul(a1, 3) ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ bmul(a1, 2) ^ bmul(a2, 3) ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ bmul(a2, 2) ^ bmul(a3, 3);
                    s[4*c+3] = bmul(a0, 3) ^ a1 ^ a2 ^ bmul(a3, 2);
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= w[4*rd + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            summary();
        end
    end

    task automatic run_enc(input logic [127:0] p, input logic [127:0] k,
                           output logic [127:0] c, output int lat);
        @(negedge clk);
        pt = p; key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        c = ct;
    endtask

    initial begin
        logic [127:0] got;
        logic [127:0] held;
        logic [127:0] pa, ka, pb, kb;
        int lat;
        int extra_done;

        build_sbox();
        repeat (4) @(negedge clk);
        chk("R1", "done in reset", 128'(done), 128'(0));
        chk("R1", "ct in reset", ct, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", 128'(done), 128'(0));
        chk("R1", "ct after reset", ct, 128'h0);

        // Known vector: whitening, rounds, final round, key chain, byte order
        run_enc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, got, lat);
        chk("R2 R4 R5 R10", "vector 1", got, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        chk("R6", "latency", 128'(lat), 128'(11));
        held = got;
        @(negedge clk);
        chk("R7", "done one cycle", 128'(done), 128'(0));
        repeat (6) @(negedge clk);
        chk("R9", "ct held while idle", ct, held);

        run_enc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, got, lat);
        chk("R2 R5 R10", "vector 2", got, 128'h3925841d02dc09fbdc118597196a0b32);
        run_enc(128'h0, 128'h0, got, lat);
        chk("R2 R4", "zero vector", got, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        chk("R6", "latency zero vector", 128'(lat), 128'(11));

        // Start during a running block
        pa = 128'hdeadbeef0123456789abcdeffedcba98; ka = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        pb = 128'h11111111222222223333333344444444; kb = 128'h55555555666666667777777788888888;
        @(negedge clk);
        pt = pa; key = ka; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        repeat (2) begin @(negedge clk); lat++; end
        pt = pb; key = kb; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat++;
        chk("R9", "ct unchanged mid-run", ct, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        chk("R8", "busy start latency", 128'(lat), 128'(11));
        chk("R8", "busy start result", ct, ref_enc(pa, ka));
        held = ct;
        extra_done = 0;
        repeat (14) begin
            @(negedge clk);
            if (done) extra_done++;
        end
        chk("R8", "no completion from ignored start", 128'(extra_done), 128'(0));
        chk("R9", "ct held after ignored start", ct, held);

        // Every byte value through each row-table of the first round
        for (int r = 0; r < 4; r++) begin
            for (int v = 0; v < 256; v++) begin
                logic [127:0] p = 128'h0;
                logic [127:0] k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
                p[127-8*r -: 8] = 8'(v);
                p[127-8*(4*((r+1)%4)+r) -: 8] = 8'(255-v);
                run_enc(p, k, got, lat);
                chk("R3", $sformatf("row %0d byte %02h", r, v), got, ref_enc(p, k));
            end
        end

        // Pseudo-random blocks and keys
        for (int n = 0; n < 48; n++) begin
            logic [127:0] p = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
            run_enc(p, k, got, lat);
            chk("R3 R4 R5 R10", $sformatf("random %0d", n), got, ref_enc(p, k));
            chk("R6", $sformatf("random latency %0d", n), 128'(lat), 128'(11));
        end

        summary();
    end

endmodule